// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a two-level translation table that sits in ordinary memory. A requester hands it a linear address, a flag that marks a write access, the physical base of the top-level directory and a large-page enable. The walker then fetches the directory entry. It either finishes at once with a 4 MiB mapping, or it fetches a table entry and finishes with a 4 KiB mapping. A cleared present flag at either level ends the walk early with a fault indication.

On the way, the walker keeps the usage flags of the entries in memory up to date. Any entry it relies on that lacks the accessed flag is written back with that flag set. A write access that ends on a 4 KiB entry also sets the dirty flag. When both flags are missing, the two updates go out in a single write. The result carries the physical address, the merged user and writable permissions, a large-page marker and the fault bit.

Both edges follow valid/ready rules. On the start side, `req_ready` is high only while the walker is idle. A request is taken on the cycle where `req_valid` and `req_ready` are both high, and `req_valid` has no effect at any other time. The finish side has no back-pressure: `rsp_valid` is high for exactly one cycle, and the result fields hold their value until the next walk ends. On the memory side, a request waits under back-pressure from `mem_req_ready` with its address, direction and data held still. Only one read is outstanding at a time. Its data comes back on a `mem_rsp_valid` cycle, which the walker always accepts. Writes return no response.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read at word address {dir_base[31:12], lin[31:22], 2'b00}. The table entry is read at {dir_entry[31:12], lin[21:12], 2'b00}. Bits [11:0] of dir_base have no effect.
- R2: A 4 KiB translation returns rsp_phys = {table_entry[31:12], lin[11:0]} with rsp_large = 0.
- R3: Take a present directory entry with bit 7 set while large_en was 1 at start. The walk returns rsp_phys = {dir_entry[31:22], lin[21:0]} and rsp_large = 1, and reads no table entry. When large_en was 0, bit 7 is ignored and the entry points to a table.
- R4: An entry at either level with bit 0 (present) clear ends the walk with rsp_fault = 1 and rsp_phys, rsp_user, rsp_rw, rsp_large all 0. No further read is made and that entry is not written.
- R5: A present entry that the walk uses and whose bit 5 (accessed) is clear is written back once, with bit 5 set, before the walk goes on. An entry whose bit 5 is already set is never written.
- R6: A write access (req_write = 1) that ends on a present table entry with bit 6 (dirty) clear writes that entry with bits 5 and 6 set, in one write. A read access never sets bit 6.
- R7: rsp_user and rsp_rw are the AND of bit 2 (user) and bit 1 (writable) over the directory and table entries. A large page takes them from the directory entry alone.
- R8: Bits 3, 4, 8 and 9 to 11 of any entry have no effect on the result. A write-back leaves every bit of the entry unchanged except bits 5 and 6.
- R9: While mem_req_valid is high and mem_req_ready is low, the request fields hold still. A read response is accepted only while a read is outstanding. Each walk makes exactly one read per level it visits.
- R10: req_ready is high only while idle, and a req_valid seen while busy starts nothing. Each walk ends with rsp_valid high for exactly one cycle.
- R11: After reset, req_ready = 1, rsp_valid = 0 and mem_req_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request |
| req_ready | output | 1 | Walker idle, can take a start |
| req_lin_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write (drives dirty update) |
| dir_base | input | 32 | Physical base of the directory, low 12 bits ignored |
| large_en | input | 1 | Allows 4 MiB directory mappings |
| rsp_valid | output | 1 | One-cycle walk-finished pulse |
| rsp_phys | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Not-present at some level |
| rsp_user | output | 1 | Merged user permission |
| rsp_rw | output | 1 | Merged writable permission |
| rsp_large | output | 1 | Translation used a 4 MiB page |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Write-back word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
Some properties hold on every cycle, and the assertions check those. They cover the memory request holding still under back-pressure and read data arriving only during a wait. They cover the finish pulse lasting one cycle and a fault zeroing the result fields. They check that page offsets pass through untouched, and that a write-back changes no bit of the entry except the two usage flags. Other behaviour shows only in the bench's scenarios, which sweep every mix of entry flags, access type and large-page enable. These scenarios cover which entry addresses are read and how many reads each walk makes. They cover the permission merge, and whether the accessed and dirty flags are really stored back in memory. They also confirm that a start pulse sent mid-walk is dropped.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Flag positions inside a 32-bit translation entry.
  localparam int unsigned FLG_PRESENT  = 0;
  localparam int unsigned FLG_WRITABLE = 1;
  localparam int unsigned FLG_USER     = 2;
  localparam int unsigned FLG_ACCESSED = 5;
  localparam int unsigned FLG_DIRTY    = 6;
  localparam int unsigned FLG_BIG      = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WAIT,
    ST_DIR_CHK,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WAIT,
    ST_TBL_CHK,
    ST_TBL_WB,
    ST_FIN
  } walk_st_e;

  typedef struct packed {
    logic present;
    logic writable;
    logic user;
    logic big;
  } ent_flags_t;

endpackage

// File: rtl/pt_entry_view.sv
// Decodes one fetched entry and forms its usage-flag write-back word.
module pt_entry_view
  import pt_walker_pkg::*;
#(
  parameter int unsigned ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent_i,
  input  logic             want_dirty_i,
  output ent_flags_t       flags_o,
  output logic [ENT_W-1:0] upd_o,
  output logic             wb_need_o
);

  logic [ENT_W-1:0] set_mask;

  always_comb begin
    flags_o.present  = ent_i[FLG_PRESENT];
    flags_o.writable = ent_i[FLG_WRITABLE];
    flags_o.user     = ent_i[FLG_USER];
    flags_o.big      = ent_i[FLG_BIG];

    set_mask               = '0;
    set_mask[FLG_ACCESSED] = 1'b1;
    set_mask[FLG_DIRTY]    = want_dirty_i;

    upd_o     = ent_i | set_mask;
    wb_need_o = (upd_o != ent_i);
  end

endmodule

// File: rtl/pt_addr_gen.sv
// Entry address and physical address formation for both levels.
// Geometry requires ADDR_W == 2*IDX_W + OFF_W and OFF_W > IDX_W.
module pt_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-OFF_W-1:0] dir_frame_i,
  input  logic [ADDR_W-OFF_W-1:0] tbl_frame_i,
  input  logic [ADDR_W-OFF_W-1:0] ent_frame_i,
  input  logic [ADDR_W-1:0]       lin_i,
  input  logic                    level_tbl_i,
  output logic [ADDR_W-1:0]       ent_addr_o,
  output logic [ADDR_W-1:0]       phys_small_o,
  output logic [ADDR_W-1:0]       phys_big_o
);

  localparam int unsigned BIG_W  = IDX_W + OFF_W;
  localparam int unsigned SLOT_W = OFF_W - IDX_W;
  localparam int unsigned HI_W   = ADDR_W - BIG_W;

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] tbl_addr;

  assign dir_addr = {dir_frame_i, lin_i[ADDR_W-1 -: IDX_W], {SLOT_W{1'b0}}};
  assign tbl_addr = {tbl_frame_i, lin_i[BIG_W-1 -: IDX_W], {SLOT_W{1'b0}}};

  assign ent_addr_o   = level_tbl_i ? tbl_addr : dir_addr;
  assign phys_small_o = {ent_frame_i, lin_i[OFF_W-1:0]};
  assign phys_big_o   = {ent_frame_i[ADDR_W-OFF_W-1 -: HI_W], lin_i[BIG_W-1:0]};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin_addr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              large_en,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic              rsp_fault,
  output logic              rsp_user,
  output logic              rsp_rw,
  output logic              rsp_large,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_rdata
);

  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned BIG_W   = IDX_W + OFF_W;

  walk_st_e          st_q;
  logic [ADDR_W-1:0] lin_q;
  logic [ADDR_W-1:0] ent_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] tbl_q;
  logic              wr_q;
  logic              big_en_q;
  logic              pu_q;
  logic              prw_q;
  logic [ADDR_W-1:0] res_phys_q;
  logic              res_fault_q;
  logic              res_user_q;
  logic              res_rw_q;
  logic              res_big_q;

  logic              base_low_unused;
  assign base_low_unused = ^dir_base[OFF_W-1:0];

  ent_flags_t        fl;
  logic [ADDR_W-1:0] upd_w;
  logic              wb_need_w;
  logic [ADDR_W-1:0] ent_addr_w;
  logic [ADDR_W-1:0] ps_w;
  logic [ADDR_W-1:0] pb_w;
  logic              at_tbl;
  logic              dir_go;
  logic              tbl_go;

  assign at_tbl = (st_q == ST_TBL_RD) || (st_q == ST_TBL_WAIT) ||
                  (st_q == ST_TBL_CHK) || (st_q == ST_TBL_WB);

  pt_entry_view #(.ENT_W(ADDR_W)) u_view (
    .ent_i        (ent_q),
    .want_dirty_i (at_tbl & wr_q),
    .flags_o      (fl),
    .upd_o        (upd_w),
    .wb_need_o    (wb_need_w)
  );

  pt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .dir_frame_i  (base_q),
    .tbl_frame_i  (tbl_q),
    .ent_frame_i  (ent_q[ADDR_W-1:OFF_W]),
    .lin_i        (lin_q),
    .level_tbl_i  (at_tbl),
    .ent_addr_o   (ent_addr_w),
    .phys_small_o (ps_w),
    .phys_big_o   (pb_w)
  );

  // A level is finished when its entry is present and either needs no
  // write-back or the write-back has just been accepted.
  assign dir_go = ((st_q == ST_DIR_CHK) && fl.present && !wb_need_w) ||
                  ((st_q == ST_DIR_WB) && mem_req_ready);
  assign tbl_go = ((st_q == ST_TBL_CHK) && fl.present && !wb_need_w) ||
                  ((st_q == ST_TBL_WB) && mem_req_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      lin_q       <= '0;
      ent_q       <= '0;
      base_q      <= '0;
      tbl_q       <= '0;
      wr_q        <= 1'b0;
      big_en_q    <= 1'b0;
      pu_q        <= 1'b0;
      prw_q       <= 1'b0;
      res_phys_q  <= '0;
      res_fault_q <= 1'b0;
      res_user_q  <= 1'b0;
      res_rw_q    <= 1'b0;
      res_big_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            lin_q    <= req_lin_addr;
            wr_q     <= req_write;
            base_q   <= dir_base[ADDR_W-1:OFF_W];
            big_en_q <= large_en;
            st_q     <= ST_DIR_RD;
          end
        end
        ST_DIR_RD:   if (mem_req_ready) st_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            ent_q <= mem_rsp_rdata;
            st_q  <= ST_DIR_CHK;
          end
        end
        ST_DIR_CHK: begin
          if (!fl.present) begin
            res_phys_q  <= '0;
            res_fault_q <= 1'b1;
            res_user_q  <= 1'b0;
            res_rw_q    <= 1'b0;
            res_big_q   <= 1'b0;
            st_q        <= ST_FIN;
          end else if (wb_need_w) begin
            st_q <= ST_DIR_WB;
          end
        end
        ST_DIR_WB:   ;
        ST_TBL_RD:   if (mem_req_ready) st_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: begin
          if (mem_rsp_valid) begin
            ent_q <= mem_rsp_rdata;
            st_q  <= ST_TBL_CHK;
          end
        end
        ST_TBL_CHK: begin
          if (!fl.present) begin
            res_phys_q  <= '0;
            res_fault_q <= 1'b1;
            res_user_q  <= 1'b0;
            res_rw_q    <= 1'b0;
            res_big_q   <= 1'b0;
            st_q        <= ST_FIN;
          end else if (wb_need_w) begin
            st_q <= ST_TBL_WB;
          end
        end
        ST_TBL_WB:   ;
        ST_FIN:      st_q <= ST_IDLE;
        default:     st_q <= ST_IDLE;
      endcase

      if (dir_go) begin
        if (fl.big && big_en_q) begin
          res_phys_q  <= pb_w;
          res_fault_q <= 1'b0;
          res_user_q  <= fl.user;
          res_rw_q    <= fl.writable;
          res_big_q   <= 1'b1;
          st_q        <= ST_FIN;
        end else begin
          tbl_q <= ent_q[ADDR_W-1:OFF_W];
          pu_q  <= fl.user;
          prw_q <= fl.writable;
          st_q  <= ST_TBL_RD;
        end
      end

      if (tbl_go) begin
        res_phys_q  <= ps_w;
        res_fault_q <= 1'b0;
        res_user_q  <= pu_q & fl.user;
        res_rw_q    <= prw_q & fl.writable;
        res_big_q   <= 1'b0;
        st_q        <= ST_FIN;
      end
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_FIN);
  assign rsp_phys      = res_phys_q;
  assign rsp_fault     = res_fault_q;
  assign rsp_user      = res_user_q;
  assign rsp_rw        = res_rw_q;
  assign rsp_large     = res_big_q;

  assign mem_req_valid = (st_q == ST_DIR_RD) || (st_q == ST_DIR_WB) ||
                         (st_q == ST_TBL_RD) || (st_q == ST_TBL_WB);
  assign mem_req_we    = (st_q == ST_DIR_WB) || (st_q == ST_TBL_WB);
  assign mem_req_addr  = ent_addr_w;
  assign mem_req_wdata = upd_w;

  // ---------------- assertions ----------------
  logic [ADDR_W-1:0] usage_mask;
  always_comb begin
    usage_mask               = '0;
    usage_mask[FLG_ACCESSED] = 1'b1;
    usage_mask[FLG_DIRTY]    = 1'b1;
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) &&
      $stable(mem_req_wdata));

  assert_rsp_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (st_q == ST_DIR_WAIT) || (st_q == ST_TBL_WAIT));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_fault_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_phys == '0 && !rsp_user && !rsp_rw && !rsp_large);

  assert_big_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_large |-> rsp_phys[BIG_W-1:0] == lin_q[BIG_W-1:0]);

  assert_small_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && !rsp_large |-> rsp_phys[OFF_W-1:0] == lin_q[OFF_W-1:0]);

  assert_wb_only_usage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |->
      ((mem_req_wdata ^ ent_q) & ~usage_mask) == '0 && mem_req_wdata[FLG_ACCESSED]);

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 4096;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] dir_base = '0;
  logic        large_en = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_phys;
  logic        rsp_fault, rsp_user, rsp_rw, rsp_large;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_lin_addr(req_lin_addr), .req_write(req_write),
    .dir_base(dir_base), .large_en(large_en),
    .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
    .rsp_user(rsp_user), .rsp_rw(rsp_rw), .rsp_large(rsp_large),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // Sparse memory model with pseudo-random back-pressure.
  logic [31:0] mem_m [logic [31:0]];
  int unsigned rd_cnt = 0;
  int unsigned wr_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem_m[mem_req_addr] = mem_req_wdata;
        wr_cnt++;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= peek(mem_req_addr);
        rd_cnt++;
      end
    end
    mem_req_ready <= rst_n && (lfsr[0] | lfsr[3]);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    logic dP, dA, dPS, dU, dRW, tP, tA, tD, tU, tRW, wr, len;
    logic [31:0] lin, base, tbase, pde, pte, daddr, taddr;
    logic [31:0] e_phys, e_pde, e_pte;
    logic e_fault, e_u, e_rw, e_big;
    int e_rd, e_wr, seen, pulses;
    int unsigned rd0, wr0;
    logic [31:0] g_phys;
    logic g_fault, g_u, g_rw, g_big;
    bit inject;

    {len, wr, tRW, tU, tD, tA, tP, dRW, dU, dPS, dA, dP} = i[11:0];
    lin   = {10'((i * 37) % 1024), 10'((i * 53 + 7) % 1024), 12'((i * 97) % 4096)};
    base  = 32'h0040_0000 + 32'((i % 16) << 12) + 32'((i * 13) & 12'hFFF);
    tbase = 32'h0200_0000 + 32'(i << 12);
    pde   = {tbase[31:12], 3'(i * 5), 1'(i >> 2), 1'b1, dPS, 1'(i >> 3), dA, 1'(i), 1'(i >> 1), dU, dRW, dP};
    if (!dP) pde = (32'hDEAD_BEE0 ^ 32'(i * 32'h0101_0100)) | {24'h0, dPS, 7'h0} & 32'hFFFF_FFFE;
    pte   = {20'hA0000 ^ 20'(i * 11), 3'(i * 3), 1'(i >> 4), 1'b0, tD, tA, 1'(i >> 1), 1'(i), tU, tRW, tP};
    if (!tP) pte = (32'h5A5A_0000 ^ 32'(i * 977)) & 32'hFFFF_FFFE;
    daddr = {base[31:12], lin[31:22], 2'b00};
    taddr = {pde[31:12], lin[21:12], 2'b00};

    // Expected result, computed from the requirements.
    e_fault = 1'b0; e_phys = '0; e_u = 1'b0; e_rw = 1'b0; e_big = 1'b0;
    e_rd = 1; e_wr = 0; e_pde = pde; e_pte = pte;
    if (!dP) begin
      e_fault = 1'b1;
    end else begin
      e_pde = pde | 32'h20;
      if (!dA) e_wr++;
      if (dPS && len) begin
        e_big = 1'b1; e_phys = {pde[31:22], lin[21:0]}; e_u = dU; e_rw = dRW;
      end else begin
        e_rd = 2;
        if (!tP) begin
          e_fault = 1'b1;
        end else begin
          e_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (e_pte != pte) e_wr++;
          e_phys = {pte[31:12], lin[11:0]}; e_u = dU & tU; e_rw = dRW & tRW;
        end
      end
    end

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    mem_m.delete();
    mem_m[daddr] = pde;
    if (daddr != taddr) mem_m[taddr] = pte;
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid = 1'b1; req_lin_addr = lin; req_write = wr;
    dir_base = base; large_en = len;
    inject = (i % 4 == 0);
    seen = 0; pulses = 0;
    g_phys = '0; g_fault = 1'b0; g_u = 1'b0; g_rw = 1'b0; g_big = 1'b0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (inject && c == 1) begin
        // Start pulse while busy with different inputs: must be dropped (R10).
        req_valid = 1'b1; req_lin_addr = ~lin; req_write = ~wr;
        dir_base = ~base; large_en = ~len;
      end
      if (rsp_valid) begin
        pulses++;
        if (seen == 0) begin
          g_phys = rsp_phys; g_fault = rsp_fault; g_u = rsp_user;
          g_rw = rsp_rw; g_big = rsp_large;
        end
        seen = 1;
      end
      if (seen != 0 && c >= 3) break;
    end
    req_valid = 1'b0;
    repeat (2) begin
      @(negedge clk);
      if (rsp_valid) pulses++;
    end

    chk("R10 single done pulse", 32'(pulses), 32'd1);
    chk("R4 fault flag", 32'(g_fault), 32'(e_fault));
    if (e_big) chk("R3 large-page phys", g_phys, e_phys);
    else       chk("R2 R4 phys", g_phys, e_phys);
    chk("R7 user merge", 32'(g_u), 32'(e_u));
    chk("R7 writable merge", 32'(g_rw), 32'(e_rw));
    chk("R3 large marker", 32'(g_big), 32'(e_big));
    chk("R1 R3 R9 read count", 32'(rd_cnt - rd0), 32'(e_rd));
    chk("R5 R6 write count", 32'(wr_cnt - wr0), 32'(e_wr));
    chk("R5 R8 directory entry after walk", peek(daddr), e_pde);
    chk("R6 R8 table entry after walk", peek(taddr), e_pte);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state, sampled while reset is still asserted.
    chk("R11 req_ready in reset", 32'(req_ready), 32'd1);
    chk("R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R11 mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", 32'(req_ready), 32'd1);
    for (int i = 0; i < N_VEC; i++) run_vec(i);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule